// File: doc/BRIEF.md
# Streaming Binary Dot-Product Accumulator

The block scores a single binary query vector against a set of stored binary reference vectors. For each reference it counts the bit positions where both the query and that reference hold a 1. Both vectors arrive over one 32-bit word stream. For every word position the query word comes first. It is followed by the word at the same position of reference 0, then reference 1, and so on up to reference N-1. The block keeps the query word, ANDs each following reference word with it and counts the ones in the result. It adds that count to the running total for that reference. All totals are held in an on-chip result memory, one entry per reference.

A pass covers every word position. It takes (N+1) accepted words per position. After the last word of the last position has passed through the pipeline, a completion flag rises. The totals can then be read back by reference number, with a read latency of one cycle. A restart pulse opens the next pass. Totals clear themselves at word position 0 of each pass, so the memory never needs an explicit clear. The datapath is split into short register stages: latch/AND, count, add, write. A bypass register covers the case where one reference is updated on consecutive positions faster than the memory round trip allows.

Top module: `dotacc_top`

## Requirements
- R1: After synchronous reset, in_ready is 1, done is 0 and rd_valid is 0.
- R2: Word ordering is fixed. At each position, the first accepted word is held as the query word and never adds to any total. The next NUM_REFS accepted words belong to references 0, 1, ... NUM_REFS-1 in that order.
- R3: Each reference word adds the number of 1 bits in (reference word AND held query word) to that reference's total. A total is the sum of these counts over all positions.
- R4: Totals are SUM_W = clog2(NUM_POS*WORD_W+1) bits wide and do not wrap. When every query and reference bit is 1, each total equals NUM_POS*WORD_W.
- R5: Every pass starts its totals from zero, whatever values the previous pass left in the result memory.
- R6: With NUM_REFS = 1 and words streamed on every cycle, the totals are still exact. Back-to-back updates to the same entry do not lose a contribution.
- R7: A word is taken only in a cycle where in_valid and in_ready are both 1. Idle cycles with in_valid low between words do not change any total.
- R8: After the final word of a pass (last position, last reference) is accepted, in_ready is 0 from the next cycle until restart. done rises on the third clock edge after the edge that accepted that word. Words offered while in_ready is 0 are ignored.
- R9: rd_en sampled with done = 1 gives rd_valid = 1 on the next cycle, with rd_data equal to the total of reference rd_addr. rd_en while done = 0 leaves rd_valid at 0.
- R10: A restart pulse while done is 1 clears done and returns in_ready to 1. The next accepted word is the query word of position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Single-cycle pulse that opens a new pass |
| in_valid | input | 1 | Stream word offered |
| in_ready | output | 1 | Block can take a stream word |
| in_word | input | WORD_W | Stream word (query or reference) |
| done | output | 1 | All totals of the pass are final |
| rd_en | input | 1 | Read request for one total |
| rd_addr | input | clog2(NUM_REFS) | Reference number to read |
| rd_valid | output | 1 | rd_data holds the requested total |
| rd_data | output | SUM_W | Total for the requested reference |

## Verification
A slip in the position or reference counters moves contributions into the wrong entry. It shows at readout as totals that differ from the model, and it ends the pass on the wrong cycle, which the bench sees as in_ready or done flipping at the wrong edge. A stale bypass or a wrong position-0 override stays hidden until the pass ends. It then shows as totals short by one word's count in the single-reference case, or carrying the previous pass's values after an all-ones pass. The stage count is checked every clock, because done must rise exactly three edges after the final accept.

// File: rtl/dotacc_pkg.sv
// Shared helpers and types for the dot-product accumulator.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package dotacc_pkg;

    // Bit width needed to index v items, never less than 1.
    function automatic int clog2_min1(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

    // Control flags travelling alongside a datapath stage.
    typedef struct packed {
        logic valid;   // stage holds a reference contribution
        logic first;   // contribution belongs to word position 0
        logic last;    // contribution is the final one of the pass
    } dotacc_tag_t;

endpackage

// File: rtl/dotacc_seq.sv
// Stream sequencer: tracks word position and slot within the position,
// holds the query word, and emits the AND of each reference word with it.
// Assumes restart is pulsed only while the pass has ended (in_ready low).
module dotacc_seq
    import dotacc_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NUM_REFS = 16,
    parameter int NUM_POS  = 32768,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output dotacc_tag_t       s1_tag,
    output logic [WORD_W-1:0] s1_and,
    output logic [IDX_W-1:0]  s1_idx
);
    localparam int RW = clog2_min1(NUM_REFS + 1);
    localparam int PW = clog2_min1(NUM_POS);
    localparam logic [RW-1:0] REF_LAST = RW'(NUM_REFS);
    localparam logic [PW-1:0] POS_LAST = PW'(NUM_POS - 1);

    logic [RW-1:0]     slot_q;    // 0 = query word, k = reference k-1
    logic [PW-1:0]     pos_q;
    logic              ended_q;
    logic [WORD_W-1:0] query_q;
    logic              accept;
    logic              final_word;

    // Handshake and end-of-pass decode.
    always_comb begin
        in_ready   = !ended_q;
        accept     = in_valid && in_ready;
        final_word = (pos_q == POS_LAST) && (slot_q == REF_LAST);
    end

    // Advance counters, hold query word and register the AND stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            pos_q   <= '0;
            ended_q <= 1'b0;
            query_q <= '0;
            s1_tag  <= '0;
            s1_and  <= '0;
            s1_idx  <= '0;
        end else begin
            s1_tag.valid <= 1'b0;
            if (restart) begin
                slot_q  <= '0;
                pos_q   <= '0;
                ended_q <= 1'b0;
            end else if (accept) begin
                if (slot_q == '0) begin
                    query_q <= in_word;
                end else begin
                    s1_tag <= '{valid: 1'b1, first: (pos_q == '0), last: final_word};
                    s1_and <= in_word & query_q;
                    s1_idx <= IDX_W'(slot_q - RW'(1));
                end
                if (slot_q == REF_LAST) begin
                    slot_q <= '0;
                    if (pos_q == POS_LAST) begin
                        pos_q   <= '0;
                        ended_q <= 1'b1;
                    end else begin
                        pos_q <= pos_q + PW'(1);
                    end
                end else begin
                    slot_q <= slot_q + RW'(1);
                end
            end
        end
    end

    // R2
    slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= REF_LAST);

    // R8
    final_accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && final_word && !restart) |=> !in_ready);

endmodule

// File: rtl/dotacc_popcnt.sv
// Population-count stage: counts the ones in the AND result and forwards
// tag and reference index by one register stage.
// Assumes WORD_W fits the CNT_W count width.
module dotacc_popcnt
    import dotacc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dotacc_tag_t       s1_tag,
    input  logic [WORD_W-1:0] s1_and,
    input  logic [IDX_W-1:0]  s1_idx,
    output dotacc_tag_t       s2_tag,
    output logic [CNT_W-1:0]  s2_cnt,
    output logic [IDX_W-1:0]  s2_idx
);
    logic [CNT_W-1:0] ones;

    // Sum the bits of the AND word.
    always_comb begin
        ones = '0;
        for (int b = 0; b < WORD_W; b++) begin
            ones = ones + CNT_W'(s1_and[b]);
        end
    end

    // Register the count with its tag and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_tag <= '0;
            s2_cnt <= '0;
            s2_idx <= '0;
        end else begin
            s2_tag <= s1_tag;
            s2_cnt <= ones;
            s2_idx <= s1_idx;
        end
    end

    // R3
    count_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_tag.valid |-> (s2_cnt == CNT_W'($countones($past(s1_and)))));

endmodule

// File: rtl/dotacc_accum.sv
// Result memory with read / add / registered write-back per reference.
// A last-write bypass covers an entry rewritten the cycle its next read
// was issued. Position 0 overrides the memory value with zero.
// Assumes indices below NUM_REFS; read port is valid one cycle after rd_en.
module dotacc_accum
    import dotacc_pkg::*;
#(
    parameter int NUM_REFS = 16,
    parameter int SUM_W    = 21,
    parameter int CNT_W    = 6,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] s1_idx,
    input  dotacc_tag_t      s2_tag,
    input  logic [CNT_W-1:0] s2_cnt,
    input  logic [IDX_W-1:0] s2_idx,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [SUM_W-1:0] rd_q,
    output logic             pass_end
);
    logic [SUM_W-1:0] mem [NUM_REFS];
    logic [SUM_W-1:0] ram_q;
    logic             s3_v, s3_last;
    logic [IDX_W-1:0] s3_idx;
    logic [SUM_W-1:0] s3_sum;
    logic             lw_v;
    logic [IDX_W-1:0] lw_idx;
    logic [SUM_W-1:0] lw_sum;
    logic             use_byp;
    logic [SUM_W-1:0] base;
    logic [SUM_W:0]   sum_wide;

    // Memory ports: pipeline read, write-back, host read.
    always_ff @(posedge clk) begin
        ram_q <= mem[s1_idx];
        if (s3_v) mem[s3_idx] <= s3_sum;
        if (rd_en) rd_q <= mem[rd_addr];
    end

    // Pick the previous total and add the new count.
    always_comb begin
        use_byp  = lw_v && (lw_idx == s2_idx);
        if (s2_tag.first)  base = '0;
        else if (use_byp)  base = lw_sum;
        else               base = ram_q;
        sum_wide = {1'b0, base} + (SUM_W+1)'(s2_cnt);
        pass_end = s3_v && s3_last;
    end

    // Register the sum for write-back and remember the last write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_v    <= 1'b0;
            s3_last <= 1'b0;
            s3_idx  <= '0;
            s3_sum  <= '0;
            lw_v    <= 1'b0;
            lw_idx  <= '0;
            lw_sum  <= '0;
        end else begin
            s3_v    <= s2_tag.valid;
            s3_last <= s2_tag.valid && s2_tag.last;
            s3_idx  <= s2_idx;
            s3_sum  <= sum_wide[SUM_W-1:0];
            if (s3_v) begin
                lw_v   <= 1'b1;
                lw_idx <= s3_idx;
                lw_sum <= s3_sum;
            end
        end
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_tag.valid |-> !sum_wide[SUM_W]);

    // R6
    bypass_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_tag.valid && !s2_tag.first && $past(s3_v) && ($past(s3_idx) == s2_idx))
        |-> (base == $past(s3_sum)));

endmodule

// File: rtl/dotacc_top.sv
// Streaming binary dot-product accumulator: query word then NUM_REFS
// reference words per position; per-reference popcount totals in memory,
// read back by index once done is high.
// Assumes NUM_REFS <= 16384 and restart only while done is high.
module dotacc_top
    import dotacc_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int NUM_REFS = 16,
    parameter int NUM_POS  = 32768,
    localparam int IDX_W   = clog2_min1(NUM_REFS),
    localparam int CNT_W   = $clog2(WORD_W + 1),
    localparam int SUM_W   = $clog2(NUM_POS * WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              done,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic              rd_valid,
    output logic [SUM_W-1:0]  rd_data
);
    dotacc_tag_t       s1_tag, s2_tag;
    logic [WORD_W-1:0] s1_and;
    logic [IDX_W-1:0]  s1_idx, s2_idx;
    logic [CNT_W-1:0]  s2_cnt;
    logic              pass_end;
    logic              done_q, rd_valid_q;

    dotacc_seq #(.WORD_W(WORD_W), .NUM_REFS(NUM_REFS), .NUM_POS(NUM_POS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .s1_tag(s1_tag), .s1_and(s1_and), .s1_idx(s1_idx)
    );

    dotacc_popcnt #(.WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_pop (
        .clk(clk), .rst_n(rst_n),
        .s1_tag(s1_tag), .s1_and(s1_and), .s1_idx(s1_idx),
        .s2_tag(s2_tag), .s2_cnt(s2_cnt), .s2_idx(s2_idx)
    );

    dotacc_accum #(.NUM_REFS(NUM_REFS), .SUM_W(SUM_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .s1_idx(s1_idx),
        .s2_tag(s2_tag), .s2_cnt(s2_cnt), .s2_idx(s2_idx),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(rd_data), .pass_end(pass_end)
    );

    // Completion flag and read-valid pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            rd_valid_q <= 1'b0;
        end else begin
            if (restart)       done_q <= 1'b0;
            else if (pass_end) done_q <= 1'b1;
            rd_valid_q <= rd_en && done_q;
        end
    end

    assign done     = done_q;
    assign rd_valid = rd_valid_q;

    // R8
    done_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !in_ready);

    // R9
    read_only_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(done));

endmodule

// File: tb/dotacc_top_test.sv
`timescale 1ns/1ps
// Bench: behavioural per-clock model for two instances (3 references and
// 1 reference, 4 word positions each), compared at every falling edge.
module dotacc_top_test;
    localparam int P  = 4;
    localparam int NR0 = 3;
    localparam int NR1 = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        vld  [2];
    logic        rsp  [2];
    logic        ren  [2];
    logic [31:0] wd   [2];
    int          radr [2];

    logic       rdy0, done0, rv0, rdy1, done1, rv1;
    logic [7:0] rd0, rd1;

    dotacc_top #(.WORD_W(32), .NUM_REFS(NR0), .NUM_POS(P)) uut (
        .clk(clk), .rst_n(rst_n), .restart(rsp[0]), .in_valid(vld[0]),
        .in_ready(rdy0), .in_word(wd[0]), .done(done0), .rd_en(ren[0]),
        .rd_addr(2'(radr[0])), .rd_valid(rv0), .rd_data(rd0)
    );

    dotacc_top #(.WORD_W(32), .NUM_REFS(NR1), .NUM_POS(P)) uut_single (
        .clk(clk), .rst_n(rst_n), .restart(rsp[1]), .in_valid(vld[1]),
        .in_ready(rdy1), .in_word(wd[1]), .done(done1), .rd_en(ren[1]),
        .rd_addr(1'(radr[1])), .rd_valid(rv1), .rd_data(rd1)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R3";

    // model state
    int          nref [2] = '{NR0, NR1};
    int          m_pos [2], m_slot [2], m_cd [2], m_rdd [2];
    bit          m_end [2], m_done [2], m_rdv [2];
    int          m_sum [2][NR0];
    logic [31:0] m_hold [2];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model of one clock edge, from the requirements.
    task automatic edge_model();
        for (int id = 0; id < 2; id++) begin
            bit nrdv;
            int nrdd;
            nrdv = ren[id] && m_done[id];
            nrdd = nrdv ? m_sum[id][radr[id]] : 0;
            if (m_cd[id] > 0) begin
                m_cd[id]--;
                if (m_cd[id] == 0) m_done[id] = 1'b1;
            end
            if (rsp[id]) begin
                m_pos[id] = 0; m_slot[id] = 0; m_end[id] = 1'b0; m_done[id] = 1'b0;
            end else if (vld[id] && !m_end[id]) begin
                if (m_slot[id] == 0) m_hold[id] = wd[id];
                else begin
                    int c;
                    c = $countones(wd[id] & m_hold[id]);
                    if (m_pos[id] == 0) m_sum[id][m_slot[id]-1] = c;
                    else m_sum[id][m_slot[id]-1] += c;
                end
                if (m_slot[id] == nref[id]) begin
                    m_slot[id] = 0;
                    if (m_pos[id] == P-1) begin
                        m_pos[id] = 0; m_end[id] = 1'b1; m_cd[id] = 3;
                    end else m_pos[id]++;
                end else m_slot[id]++;
            end
            m_rdv[id] = nrdv;
            m_rdd[id] = nrdd;
        end
    endtask

    // Compare every output of both instances against the model.
    task automatic compare();
        check(rdy0 == !m_end[0], "R8 in_ready", rdy0, !m_end[0]);
        check(done0 == m_done[0], "R8 done", done0, m_done[0]);
        check(rv0 == m_rdv[0], "R9 rd_valid", rv0, m_rdv[0]);
        if (m_rdv[0]) check(rd0 == 8'(m_rdd[0]), cur_req, rd0, m_rdd[0]);
        check(rdy1 == !m_end[1], "R8 in_ready single", rdy1, !m_end[1]);
        check(done1 == m_done[1], "R8 done single", done1, m_done[1]);
        check(rv1 == m_rdv[1], "R9 rd_valid single", rv1, m_rdv[1]);
        if (m_rdv[1]) check(rd1 == 8'(m_rdd[1]), cur_req, rd1, m_rdd[1]);
    endtask

    task automatic step();
        @(posedge clk);
        edge_model();
        @(negedge clk);
        compare();
    endtask

    // mode 0 random, 1 all ones, 2 zero query / ones refs, 3 random with bubbles
    task automatic run_pass(input int id, input int mode, input string req);
        cur_req = req;
        for (int p = 0; p < P; p++) begin
            for (int s = 0; s <= nref[id]; s++) begin
                if (mode == 3) begin
                    while ($urandom % 3 == 0) begin
                        vld[id] = 1'b0; wd[id] = $urandom; step();   // R7 idle word ignored
                    end
                end
                vld[id] = 1'b1;
                case (mode)
                    1: wd[id] = 32'hFFFF_FFFF;
                    2: wd[id] = (s == 0) ? 32'h0 : 32'hFFFF_FFFF;
                    default: wd[id] = $urandom;
                endcase
                ren[id] = (mode == 0 && p == 1 && s == 0);  // R9 read before done ignored
                radr[id] = 0;
                step();
                ren[id] = 1'b0;
            end
        end
        vld[id] = 1'b0;
        for (int k = 0; k < 10 && !m_done[id]; k++) step();
        // R8 words offered after the pass closed are ignored
        vld[id] = 1'b1; wd[id] = 32'hFFFF_FFFF; step(); step();
        vld[id] = 1'b0;
        for (int a = 0; a < nref[id]; a++) begin
            ren[id] = 1'b1; radr[id] = a; step();
        end
        ren[id] = 1'b0; step();
        rsp[id] = 1'b1; step(); rsp[id] = 1'b0;
        // R10 restart reopens the stream
        if (id == 0) check(rdy0 == 1'b1 && done0 == 1'b0, "R10", {done0, rdy0}, 1);
        else         check(rdy1 == 1'b1 && done1 == 1'b0, "R10", {done1, rdy1}, 1);
    endtask

    initial begin
        for (int id = 0; id < 2; id++) begin
            vld[id] = 0; rsp[id] = 0; ren[id] = 0; wd[id] = 0; radr[id] = 0;
            m_pos[id] = 0; m_slot[id] = 0; m_cd[id] = 0; m_end[id] = 0;
            m_done[id] = 0; m_rdv[id] = 0; m_rdd[id] = 0; m_hold[id] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(rdy0 && !done0 && !rv0, "R1", {rdy0, done0, rv0}, 4);
        check(rdy1 && !done1 && !rv1, "R1", {rdy1, done1, rv1}, 4);
        run_pass(0, 0, "R3");
        run_pass(0, 1, "R4");
        run_pass(0, 2, "R2 R5");
        run_pass(0, 3, "R7");
        run_pass(1, 0, "R6");
        run_pass(1, 1, "R6 R4");
        run_pass(1, 3, "R6 R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule